// File: doc/BRIEF.md
# One-Time-Programmable Store Programming Port

This block is the device-side logic that gives an external programmer access to a one-time-programmable program store through a narrow port. The port has no address pins. A four-bit mode code picks one of four operations: rewind the address to zero, write a byte, read a byte back for verification, or hold off. An address-update clock moves an internal byte pointer forward, and an eight-bit data path carries bytes in both directions.

Each 16-bit stored word appears as two bytes. The upper half sits at the even byte address and the lower half at the odd one. The pointer advances by one byte on the falling edge of the third update-clock pulse in every group of four. It stops at the last byte instead of wrapping.

Writes go out as a byte-enabled strobe to a memory array outside the block. They are committed only while a digital program-enable input is high; this input stands in for the analog programming-voltage detection. Reads drive the data path, and the output enable is raised only in read/verify mode. All pins are sampled by the block's own clock and reset is active low.

Top module: `otp_prog_port`

## Requirements
- R1: The mode code (md[0] is the lowest bit) 4'b0101 selects address rewind. While it is present, the byte pointer and the two-bit pulse counter return to zero on the next clock.
- R2: Outside rewind mode, a falling edge on upd_clk advances the pulse counter modulo four. The byte pointer grows by one only on the edge that moves the counter from 2 to 3, which is the third edge of each group. No other event changes the pointer.
- R3: The byte pointer never passes 2*WORDS-1. Further group-completing edges leave it at that value.
- R4: Mode code 4'b1100 is read/verify. One clock after it is seen, d_oe is 1 and d_out carries bits 15:8 of the addressed word when the byte pointer is even, and bits 7:0 when it is odd. Outside this mode d_out is 0.
- R5: d_oe is 0 one clock after any mode code other than 4'b1100. This covers inhibit (4'b11x1), write, rewind and undefined codes.
- R6: A falling edge of md[0] that lands on write code 4'b1110 while prog_en is 1 produces a one-clock mem_we one clock later. It also sets mem_waddr to the pointer divided by two. For an even pointer it sets mem_be=2'b10 with d_in on mem_wdata[15:8]; for an odd pointer it sets mem_be=2'b01 with d_in on mem_wdata[7:0].
- R7: With prog_en at 0, a write edge produces no mem_we, and the addressed byte later reads back unchanged.
- R8: Holding write mode for several clocks produces exactly one strobe per md[0] falling edge.
- R9: After reset, d_oe, mem_we and mem_raddr are all 0.
- R10: upd_clk edges seen during rewind mode are not counted. After leaving rewind, the first two edges leave the pointer at 0 and the third moves it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Program-mode enable; writes are committed only while high |
| md | input | 4 | Operation mode code, md[0] being the lowest bit |
| upd_clk | input | 1 | Address-update clock from the programmer |
| d_in | input | 8 | Byte arriving from the data pads |
| d_out | output | 8 | Byte driven to the data pads during read/verify |
| d_oe | output | 1 | Output enable of the data pads |
| mem_raddr | output | WAW | Word address for the asynchronous array read |
| mem_rdata | input | 16 | Word returned by the array |
| mem_we | output | 1 | One-clock write strobe |
| mem_be | output | 2 | Byte enables: bit 1 upper half, bit 0 lower half |
| mem_waddr | output | WAW | Word address of the write |
| mem_wdata | output | 16 | Write data, placed in the enabled half |

## Verification
The bench targets the address arithmetic. A pointer that counted the wrong edge of the four-pulse group would show the wrong byte lane right after the second or third pulse. A counter that kept running during rewind would advance one edge early once rewind ends. A pointer that wrapped instead of saturating would jump back to word zero in the long pulse run. On the write side, the bench holds write mode well past the edge and also strikes while program-enable is low. A level-triggered commit would then show repeated strobes, and a commit that ignored the enable would corrupt a byte that is later read back.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MODE_NONE,
        MODE_CLEAR,
        MODE_WRITE,
        MODE_READ,
        MODE_INHIBIT
    } prog_mode_e;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic [3:0]  md,
    output prog_mode_e  mode
);

    always_comb begin
        casez (md)
            4'b0101: mode = MODE_CLEAR;
            4'b1110: mode = MODE_WRITE;
            4'b1100: mode = MODE_READ;
            4'b11?1: mode = MODE_INHIBIT;
            default: mode = MODE_NONE;
        endcase
    end

endmodule

// File: rtl/otp_pin_sense.sv
module otp_pin_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_clk,
    input  logic md0,
    output logic upd_fall,
    output logic md0_fall
);

    typedef struct packed {
        logic upd;
        logic md0;
    } pins_t;

    pins_t p_d, p_q;

    always_comb begin
        p_d.upd = upd_clk;
        p_d.md0 = md0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign upd_fall = p_q.upd & ~upd_clk;
    assign md0_fall = p_q.md0 & ~md0;

endmodule

// File: rtl/otp_addr_seq.sv
module otp_addr_seq
    import otp_pkg::*;
#(
    parameter  int BYTES = 24320,
    localparam int AW    = $clog2(BYTES),
    localparam int LAST  = BYTES - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  prog_mode_e    mode,
    input  logic          upd_fall,
    output logic [AW-1:0] byte_addr
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [1:0]    phase;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mode == MODE_CLEAR) begin
            s_d.addr  = '0;
            s_d.phase = '0;
        end else if (upd_fall) begin
            s_d.phase = s_q.phase + 2'd1;
            if (s_q.phase == 2'd2 && s_q.addr != AW'(LAST))
                s_d.addr = s_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_addr = s_q.addr;

    // R1: rewind mode returns pointer and group counter to zero
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CLEAR) |=> (s_q.addr == '0 && s_q.phase == 2'd0));

    // R2: without an update edge the pointer holds
    assert_hold_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_fall && mode != MODE_CLEAR) |=> $stable(s_q.addr));

    // R2: any move outside rewind is a single step
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_CLEAR) |=> (s_q.addr == $past(s_q.addr) ||
                                  s_q.addr == $past(s_q.addr) + 1'b1));

    // R3: pointer stays inside the byte space
    assert_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.addr <= AW'(LAST));

endmodule

// File: rtl/otp_byte_lane.sv
module otp_byte_lane
    import otp_pkg::*;
#(
    parameter  int BYTES = 24320,
    localparam int AW    = $clog2(BYTES),
    localparam int WAW   = AW - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  prog_mode_e     mode,
    input  logic           md0_fall,
    input  logic           prog_en,
    input  logic [7:0]     d_in,
    input  logic [AW-1:0]  byte_addr,
    input  logic [15:0]    rdata,
    output logic [7:0]     d_out,
    output logic           d_oe,
    output logic           we,
    output logic [1:0]     be,
    output logic [WAW-1:0] waddr,
    output logic [15:0]    wdata
);

    typedef struct packed {
        logic           oe;
        logic [7:0]     dout;
        logic           we;
        logic [1:0]     be;
        logic [WAW-1:0] waddr;
        logic [15:0]    wdata;
    } lane_t;

    lane_t l_d, l_q;
    logic  commit;
    logic  odd;

    assign odd    = byte_addr[0];
    assign commit = md0_fall && (mode == MODE_WRITE) && prog_en;

    always_comb begin
        l_d       = l_q;
        l_d.oe    = (mode == MODE_READ);
        l_d.dout  = '0;
        if (mode == MODE_READ)
            l_d.dout = odd ? rdata[7:0] : rdata[15:8];
        l_d.we    = commit;
        l_d.be    = '0;
        l_d.wdata = '0;
        if (commit) begin
            l_d.waddr = byte_addr[AW-1:1];
            l_d.be    = odd ? 2'b01 : 2'b10;
            l_d.wdata = odd ? {8'h00, d_in} : {d_in, 8'h00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign d_out = l_q.dout;
    assign d_oe  = l_q.oe;
    assign we    = l_q.we;
    assign be    = l_q.be;
    assign waddr = l_q.waddr;
    assign wdata = l_q.wdata;

    // R5: pads are released one clock after any non-read code
    assert_release_pads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_READ) |=> !l_q.oe);

    // R4: even pointer reads the upper half of the word
    assert_even_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_READ && !odd) |=> (l_q.oe && l_q.dout == $past(rdata[15:8])));

    // R7: no strobe without program enable
    assert_need_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> !l_q.we);

    // R8: a strobe never lasts two clocks
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        l_q.we |=> !l_q.we);

    // R6: a strobe enables exactly one half
    assert_one_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        l_q.we |-> $countones(l_q.be) == 1);

endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
    import otp_pkg::*;
#(
    parameter  int WORDS = 12160,
    localparam int BYTES = 2 * WORDS,
    localparam int AW    = $clog2(BYTES),
    localparam int WAW   = AW - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prog_en,
    input  logic [3:0]     md,
    input  logic           upd_clk,
    input  logic [7:0]     d_in,
    output logic [7:0]     d_out,
    output logic           d_oe,
    output logic [WAW-1:0] mem_raddr,
    input  logic [15:0]    mem_rdata,
    output logic           mem_we,
    output logic [1:0]     mem_be,
    output logic [WAW-1:0] mem_waddr,
    output logic [15:0]    mem_wdata
);

    prog_mode_e    mode;
    logic          upd_fall;
    logic          md0_fall;
    logic [AW-1:0] byte_addr;

    otp_mode_decode u_decode (
        .md   (md),
        .mode (mode)
    );

    otp_pin_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_clk  (upd_clk),
        .md0      (md[0]),
        .upd_fall (upd_fall),
        .md0_fall (md0_fall)
    );

    otp_addr_seq #(.BYTES(BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .upd_fall  (upd_fall),
        .byte_addr (byte_addr)
    );

    otp_byte_lane #(.BYTES(BYTES)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .md0_fall  (md0_fall),
        .prog_en   (prog_en),
        .d_in      (d_in),
        .byte_addr (byte_addr),
        .rdata     (mem_rdata),
        .d_out     (d_out),
        .d_oe      (d_oe),
        .we        (mem_we),
        .be        (mem_be),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata)
    );

    assign mem_raddr = byte_addr[AW-1:1];

endmodule

// File: tb/test_otp_prog_port.sv
`timescale 1ns/1ps
module test_otp_prog_port;

    localparam int WORDS = 16;
    localparam int BYTES = 2 * WORDS;
    localparam int WAW   = $clog2(BYTES) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           prog_en = 1'b1;
    logic [3:0]     md = 4'b1111;
    logic           upd_clk = 1'b0;
    logic [7:0]     d_in = 8'h00;
    logic [7:0]     d_out;
    logic           d_oe;
    logic [WAW-1:0] mem_raddr;
    logic [15:0]    mem_rdata;
    logic           mem_we;
    logic [1:0]     mem_be;
    logic [WAW-1:0] mem_waddr;
    logic [15:0]    mem_wdata;

    int vectors = 0;
    int fails   = 0;
    int we_seen = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    otp_prog_port #(.WORDS(WORDS)) i_otp_prog_port (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .md(md), .upd_clk(upd_clk),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_be(mem_be),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    // behavioural array attached to the port
    logic [15:0] mem [0:WORDS-1];
    assign mem_rdata = mem[mem_raddr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
        end else if (mem_we) begin
            if (mem_be[1]) mem[mem_waddr][15:8] <= mem_wdata[15:8];
            if (mem_be[0]) mem[mem_waddr][7:0]  <= mem_wdata[7:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model, updated on each rising edge from the driven pins
    int       ref_addr, ref_ph;
    bit       prev_upd, prev_md0;
    bit       e_oe, e_we;
    bit [7:0] e_dout;
    bit [1:0] e_be;
    bit [15:0] e_wd;
    int       e_wa;
    bit [15:0] gold [WORDS];

    always @(posedge clk) begin
        if (!rst_n) begin
            ref_addr = 0; ref_ph = 0; prev_upd = 0; prev_md0 = 0;
            e_oe = 0; e_we = 0; e_dout = 0; e_be = 0; e_wd = 0; e_wa = 0;
            for (int i = 0; i < WORDS; i++) gold[i] = 16'hFFFF;
        end else begin
            bit is_clear, is_write, is_read, ufall, mfall;
            bit n_we; bit [1:0] n_be; bit [15:0] n_wd; int n_wa;
            bit n_oe; bit [7:0] n_dout;
            is_clear = (md == 4'b0101);
            is_write = (md == 4'b1110);
            is_read  = (md == 4'b1100);
            ufall    = prev_upd && !upd_clk;
            mfall    = prev_md0 && !md[0];
            n_oe   = is_read;
            n_dout = 0;
            if (is_read)
                n_dout = (ref_addr % 2 == 0) ? gold[ref_addr/2][15:8] : gold[ref_addr/2][7:0];
            n_we = mfall && is_write && prog_en;
            n_be = 0; n_wd = 0; n_wa = e_wa;
            if (n_we) begin
                n_wa = ref_addr / 2;
                if (ref_addr % 2 == 0) begin n_be = 2'b10; n_wd = {d_in, 8'h00}; end
                else                   begin n_be = 2'b01; n_wd = {8'h00, d_in}; end
            end
            if (e_we) begin
                if (e_be[1]) gold[e_wa][15:8] = e_wd[15:8];
                if (e_be[0]) gold[e_wa][7:0]  = e_wd[7:0];
            end
            e_oe = n_oe; e_dout = n_dout; e_we = n_we; e_be = n_be; e_wd = n_wd; e_wa = n_wa;
            if (is_clear) begin
                ref_addr = 0; ref_ph = 0;
            end else if (ufall) begin
                if (ref_ph == 2 && ref_addr < BYTES - 1) ref_addr++;
                ref_ph = (ref_ph + 1) % 4;
            end
            prev_upd = upd_clk;
            prev_md0 = md[0];
        end
    end

    // per-clock comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_we) we_seen++;
            chk(d_oe === e_oe, "R5 d_oe", d_oe, e_oe);
            chk(d_out === e_dout, "R4 d_out", d_out, e_dout);
            chk(mem_we === e_we, "R6 mem_we", mem_we, e_we);
            if (e_we) begin
                chk(mem_be === e_be, "R6 mem_be", mem_be, e_be);
                chk(mem_wdata === e_wd, "R6 mem_wdata", mem_wdata, e_wd);
                chk(int'(mem_waddr) == e_wa, "R6 mem_waddr", mem_waddr, e_wa);
            end
            chk(int'(mem_raddr) == ref_addr / 2, "R2 mem_raddr", mem_raddr, ref_addr / 2);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulses(input int n);
        repeat (n) begin
            upd_clk = 1'b1; tick(2);
            upd_clk = 1'b0; tick(2);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        md = 4'b1111; tick(2);
        d_in = b;
        md = 4'b1110; tick(3);
        md = 4'b1111; tick(2);
    endtask

    task automatic rewind();
        md = 4'b0101; tick(2);
        md = 4'b1111; tick(2);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            vectors++;
            $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

    initial begin
        int base;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        chk(d_oe == 1'b0, "R9 reset d_oe", d_oe, 0);
        chk(mem_we == 1'b0, "R9 reset mem_we", mem_we, 0);
        chk(mem_raddr == '0, "R9 reset mem_raddr", mem_raddr, 0);

        // program four words, upper byte first
        rewind();
        chk(mem_raddr == '0, "R1 rewind", mem_raddr, 0);
        base = we_seen;
        for (int i = 0; i < 4; i++) begin
            wr_byte(8'hA0 + 8'(i)); pulses(4);
            wr_byte(8'h50 + 8'(i)); pulses(4);
        end
        chk(we_seen - base == 8, "R8 strobe count", we_seen - base, 8);

        // write attempt with enable low at byte 8
        base = we_seen;
        prog_en = 1'b0;
        wr_byte(8'h33);
        prog_en = 1'b1;
        chk(we_seen == base, "R7 blocked strobe", we_seen - base, 0);

        // read back
        rewind();
        md = 4'b1100; tick(2);
        chk(d_oe == 1'b1, "R4 oe in read", d_oe, 1);
        chk(d_out == 8'hA0, "R4 even lane", d_out, 8'hA0);
        pulses(4);
        chk(d_out == 8'h50, "R4 odd lane", d_out, 8'h50);
        pulses(4 * 7);
        chk(d_out == 8'hFF, "R7 byte unchanged", d_out, 8'hFF);
        md = 4'b1101; tick(2);
        chk(d_oe == 1'b0, "R5 inhibit releases", d_oe, 0);

        // edges during rewind are not counted
        md = 4'b0101; tick(1);
        pulses(3);
        md = 4'b1100; tick(1);
        pulses(2); tick(1);
        chk(d_out == 8'hA0, "R10 two edges hold", d_out, 8'hA0);
        pulses(1); tick(1);
        chk(d_out == 8'h50, "R10 third edge steps", d_out, 8'h50);

        // saturation at the last byte
        rewind();
        pulses(4 * (BYTES + 6));
        chk(int'(mem_raddr) == WORDS - 1, "R3 saturate", mem_raddr, WORDS - 1);
        wr_byte(8'h5A);
        pulses(8);
        md = 4'b1100; tick(2);
        chk(int'(mem_raddr) == WORDS - 1, "R3 still last", mem_raddr, WORDS - 1);
        chk(d_out == 8'h5A, "R3 last byte lane", d_out, 8'h5A);
        md = 4'b1111; tick(3);

        done = 1'b1;
        finish_run();
    end

endmodule